// File: doc/BRIEF.md
# Guarded Word Store Unit

This block is the store side of a load/store functional unit. It executes one 32-bit word store per accepted operation. The operation carries a guard bit, a base address, a data word, a 7-bit signed displacement field and an endianness mode bit. The unit scales the displacement by the word size and adds it to the base. It checks that the result is word aligned, reorders the data bytes for the selected byte order, and presents one write beat on a byte-addressed memory port in the cycle after the operation is accepted.

A store whose guard bit is 0 has no side effects. A guarded store that is misaligned writes nothing. Instead it sets a sticky misalignment flag and, when trapping is enabled, raises a trap request. The trap request stays pending until the next interruptible jump acknowledges it. The trap logic is a two-state machine. In state TRAP_IDLE, an enabled misaligned store takes it to TRAP_PEND (transition "raise"). In TRAP_PEND, an acknowledge strobe takes it back to TRAP_IDLE (transition "service"), unless another enabled misaligned store arrives in the same cycle, in which case it stays in TRAP_PEND (transition "re-arm").

Top module: `gstore_unit`

## Requirements
- R1: In the cycle after an accepted operation, mem_addr equals op_base plus the sign-extended op_disp multiplied by 4, taken modulo 2^32. This holds whether or not a write takes place.
- R2: op_done is 1 in exactly the cycle after each cycle in which op_valid is 1, and 0 otherwise.
- R3: When op_guard is 0 there is no memory write. mis_flag and trap_req also keep their values.
- R4: With mode_big at 0 (little-endian), an aligned guarded store drives mem_we 1, mem_be 4'b1111 and mem_wdata equal to op_src. Byte lane k (bits 8k+7:8k) is written to address mem_addr+k.
- R5: With mode_big at 1 (big-endian), lane k of mem_wdata carries bits 31-8k:24-8k of op_src, so the most significant byte goes to mem_addr+0.
- R6: A guarded store whose effective address has bits 1:0 not both zero writes nothing (mem_we 0, mem_be 0) and sets mis_flag in the next cycle.
- R7: mis_flag stays 1 until mse_clear is 1 in some cycle. If a new misaligned store and mse_clear fall in the same cycle, the flag stays set.
- R8: A misaligned guarded store with trap_en 1 makes trap_req 1 in the next cycle. trap_req then holds until ijmp_strobe is 1. If a strobe coincides with a new trapping store, trap_req stays 1.
- R9: A misaligned guarded store with trap_en 0 sets mis_flag but does not raise trap_req.
- R10: During and right after reset, every output is 0.
- R11: Displacement field 7'h40 gives an offset of -256, and 7'h3F gives +252.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_guard | input | 1 | Bit 0 of the guard register |
| op_base | input | 32 | Base address register value |
| op_src | input | 32 | Data word to store |
| op_disp | input | 7 | Signed displacement field, in words |
| mode_big | input | 1 | 1 selects big-endian byte order |
| trap_en | input | 1 | Enables a trap on a misaligned store |
| mse_clear | input | 1 | Clears the sticky misalignment flag |
| ijmp_strobe | input | 1 | Interruptible jump; acknowledges a pending trap |
| op_done | output | 1 | Operation completed |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data, lane k goes to mem_addr+k |
| mem_be | output | 4 | Byte enables, one per lane |
| mis_flag | output | 1 | Sticky misaligned-store flag |
| trap_req | output | 1 | Pending trap request |

## Verification
Two pairs of events can land in the same cycle. A new misaligned store can coincide with mse_clear, and a new trapping store can coincide with the ijmp_strobe acknowledge. The bench provokes each pair by raising the clear or acknowledge input in the same cycle as op_valid. In both cases it expects the new event to win: mis_flag stays 1 and trap_req stays 1. It then applies the clear or acknowledge alone and expects the output to drop, which shows that the previous state really was overridden rather than left untouched.

// File: rtl/gstore_pkg.sv
package gstore_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        TRAP_IDLE = 1'b0,
        TRAP_PEND = 1'b1
    } trap_state_e;

endpackage

// File: rtl/gstore_ea.sv
module gstore_ea #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 7,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea,
    output logic              misal
);

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        offset   = disp_ext << SHIFT;
        ea       = base + offset;
        misal    = |ea[SHIFT-1:0];
    end

endmodule

// File: rtl/gstore_lanes.sv
module gstore_lanes #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int LB     = 2
) (
    input  logic              big,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] dout
);

    localparam logic [LB-1:0] REV_MASK = LB'(LANES - 1);

    logic [LB-1:0] flip;

    always_comb flip = big ? REV_MASK : '0;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LB-1:0] pick;
        always_comb begin
            pick = LB'(k) ^ flip;
            dout[k*8 +: 8] = src[pick*8 +: 8];
        end
    end

endmodule

// File: rtl/gstore_trap.sv
module gstore_trap
    import gstore_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mis_evt,
    input  logic trap_en,
    input  logic flag_clr,
    input  logic ack,
    output logic mis_flag,
    output logic trap_req
);

    trap_state_e state_q, state_d;
    logic        raise;

    always_comb raise = mis_evt & trap_en;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        trap_req = 1'b0;
        unique case (state_q)
            TRAP_IDLE: begin
                if (raise) state_d = TRAP_PEND;
            end
            TRAP_PEND: begin
                trap_req = 1'b1;
                if (ack && !raise) state_d = TRAP_IDLE;
            end
            default: state_d = TRAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        mis_flag <= 1'b0;
        else if (mis_evt)  mis_flag <= 1'b1;
        else if (flag_clr) mis_flag <= 1'b0;
    end

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mis_flag && !flag_clr |=> mis_flag);
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        mis_evt |=> mis_flag);
    a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> trap_req);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && !ack |=> trap_req);

endmodule

// File: rtl/gstore_unit.sv
module gstore_unit
    import gstore_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DISP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_guard,
    input  logic [ADDR_W-1:0] op_base,
    input  logic [DATA_W-1:0] op_src,
    input  logic [DISP_W-1:0] op_disp,
    input  logic              mode_big,
    input  logic              trap_en,
    input  logic              mse_clear,
    input  logic              ijmp_strobe,
    output logic              op_done,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W/BYTE_W-1:0] mem_be,
    output logic              mis_flag,
    output logic              trap_req
);

    localparam int LANES = DATA_W / BYTE_W;
    localparam int SHIFT = $clog2(LANES);

    logic [ADDR_W-1:0] ea;
    logic              misal;
    logic [DATA_W-1:0] lane_data;
    logic              commit, do_write, mis_evt;

    gstore_ea #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SHIFT(SHIFT)) ea_i (
        .base (op_base),
        .disp (op_disp),
        .ea   (ea),
        .misal(misal)
    );

    gstore_lanes #(.DATA_W(DATA_W), .LANES(LANES), .LB(SHIFT)) lanes_i (
        .big (mode_big),
        .src (op_src),
        .dout(lane_data)
    );

    always_comb begin
        commit   = op_valid & op_guard;
        do_write = commit & ~misal;
        mis_evt  = commit & misal;
    end

    gstore_trap trap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mis_evt (mis_evt),
        .trap_en (trap_en),
        .flag_clr(mse_clear),
        .ack     (ijmp_strobe),
        .mis_flag(mis_flag),
        .trap_req(trap_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_done   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_be    <= '0;
        end else begin
            op_done <= op_valid;
            mem_we  <= do_write;
            mem_be  <= do_write ? '1 : '0;
            if (op_valid) begin
                mem_addr  <= ea;
                mem_wdata <= do_write ? lane_data : '0;
            end
        end
    end

    a_r2_done: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> op_done);
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !op_done);
    a_r1_aligned_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[SHIFT-1:0] == '0);
    a_r3_guard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_guard && !mse_clear && !ijmp_strobe |=>
            !mem_we && mis_flag == $past(mis_flag) && trap_req == $past(trap_req));
    a_r6_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_guard && misal |=> !mem_we && mem_be == '0 && mis_flag);
    a_r9_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_guard && misal && !trap_en && !trap_req |=> !trap_req);

endmodule

// File: tb/gstore_unit_tb.sv
`timescale 1ns/1ps
module gstore_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, op_guard, mode_big, trap_en, mse_clear, ijmp_strobe;
    logic [31:0] op_base, op_src;
    logic [6:0]  op_disp;
    logic        op_done, mem_we, mis_flag, trap_req;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    gstore_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_guard(op_guard),
        .op_base(op_base), .op_src(op_src), .op_disp(op_disp),
        .mode_big(mode_big), .trap_en(trap_en), .mse_clear(mse_clear),
        .ijmp_strobe(ijmp_strobe), .op_done(op_done), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mis_flag(mis_flag), .trap_req(trap_req)
    );

    typedef struct packed {
        logic        guard;
        logic [31:0] base;
        logic [31:0] src;
        logic [6:0]  disp;
        logic        big;
        logic        exp_we;
        logic [31:0] exp_addr;
        logic [31:0] exp_data;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h00000cfc, 32'h44332211, 7'h01, 1'b1, 1'b1, 32'h00000d00, 32'h11223344},
        '{1'b1, 32'h00000d0c, 32'haabbccdd, 7'h7e, 1'b1, 1'b1, 32'h00000d04, 32'hddccbbaa},
        '{1'b0, 32'h00000d0c, 32'haabbccdd, 7'h7e, 1'b1, 1'b0, 32'h00000d04, 32'h00000000},
        '{1'b1, 32'h00002000, 32'h12345678, 7'h03, 1'b0, 1'b1, 32'h0000200c, 32'h12345678},
        '{1'b1, 32'h00001000, 32'hdeadbeef, 7'h40, 1'b0, 1'b1, 32'h00000f00, 32'hdeadbeef},
        '{1'b1, 32'h00001000, 32'h01020304, 7'h3f, 1'b1, 1'b1, 32'h000010fc, 32'h04030201},
        '{1'b1, 32'hfffffffc, 32'hcafef00d, 7'h02, 1'b0, 1'b1, 32'h00000004, 32'hcafef00d},
        '{1'b1, 32'h00000010, 32'h89abcdef, 7'h7c, 1'b1, 1'b1, 32'h00000000, 32'hefcdab89},
        '{1'b0, 32'h00000040, 32'h55aa55aa, 7'h00, 1'b0, 1'b0, 32'h00000040, 32'h00000000}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        op_valid = 0; op_guard = 0; op_base = 0; op_src = 0; op_disp = 0;
        mode_big = 0; trap_en = 0; mse_clear = 0; ijmp_strobe = 0;
    endtask

    // one operation; returns at the negedge where its results are visible
    task automatic do_op(input logic g, input logic [31:0] b, input logic [31:0] s,
                         input logic [6:0] d, input logic big, input logic ten,
                         input logic clr, input logic ack);
        @(negedge clk);
        op_valid = 1; op_guard = g; op_base = b; op_src = s; op_disp = d;
        mode_big = big; trap_en = ten; mse_clear = clr; ijmp_strobe = ack;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic pulse(input logic clr, input logic ack);
        @(negedge clk);
        mse_clear = clr; ijmp_strobe = ack;
        @(negedge clk);
        clear_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R10", "done in reset", op_done, 0);
        chk("R10", "we in reset", mem_we, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R10", "addr", mem_addr, 0);
        chk("R10", "wdata", mem_wdata, 0);
        chk("R10", "be", mem_be, 0);
        chk("R10", "flag", mis_flag, 0);
        chk("R10", "trap", trap_req, 0);

        // table walk: R1 R3 R4 R5 R11 R2
        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].guard, VECS[i].base, VECS[i].src, VECS[i].disp,
                  VECS[i].big, 1'b0, 1'b0, 1'b0);
            chk("R2", $sformatf("vec%0d done", i), op_done, 1);
            chk("R1", $sformatf("vec%0d addr", i), mem_addr, VECS[i].exp_addr);
            chk("R3", $sformatf("vec%0d we", i), mem_we, VECS[i].exp_we);
            chk("R4", $sformatf("vec%0d be", i), mem_be, VECS[i].exp_we ? 4'hf : 4'h0);
            if (VECS[i].exp_we)
                chk(VECS[i].big ? "R5" : "R4", $sformatf("vec%0d data", i),
                    mem_wdata, VECS[i].exp_data);
        end
        chk("R3", "flag after table", mis_flag, 0);
        chk("R3", "trap after table", trap_req, 0);

        // misaligned, no trap enable: R6 R9
        do_op(1, 32'h1001, 32'h11111111, 7'h00, 0, 0, 0, 0);
        chk("R6", "misal we", mem_we, 0);
        chk("R6", "misal be", mem_be, 0);
        chk("R6", "misal flag", mis_flag, 1);
        chk("R9", "no trap", trap_req, 0);
        @(negedge clk);
        chk("R2", "idle done", op_done, 0);
        chk("R7", "flag sticky idle", mis_flag, 1);
        do_op(1, 32'h80, 32'h0badcafe, 7'h00, 0, 0, 0, 0);
        chk("R4", "aligned after misal", mem_we, 1);
        chk("R7", "flag sticky store", mis_flag, 1);
        pulse(1, 0);
        chk("R7", "flag cleared", mis_flag, 0);

        // guard off misaligned with trap enabled: R3
        do_op(0, 32'h1002, 32'h0, 7'h00, 0, 1, 0, 0);
        chk("R3", "guard off flag", mis_flag, 0);
        chk("R3", "guard off trap", trap_req, 0);
        chk("R3", "guard off we", mem_we, 0);

        // trap raise, hold, service: R8
        do_op(1, 32'h1003, 32'h0, 7'h00, 0, 1, 0, 0);
        chk("R8", "trap raised", trap_req, 1);
        chk("R6", "flag set", mis_flag, 1);
        repeat (3) @(negedge clk);
        chk("R8", "trap held", trap_req, 1);
        pulse(0, 1);
        chk("R8", "trap serviced", trap_req, 0);

        // coincident ack and new trap
        do_op(1, 32'h2002, 32'h0, 7'h00, 1, 1, 0, 0);
        chk("R8", "trap again", trap_req, 1);
        do_op(1, 32'h2006, 32'h0, 7'h00, 1, 1, 0, 1);
        chk("R8", "re-arm beats ack", trap_req, 1);
        pulse(0, 1);
        chk("R8", "ack alone", trap_req, 0);

        // coincident clear and new misaligned store
        do_op(1, 32'h3001, 32'h0, 7'h00, 0, 0, 1, 0);
        chk("R7", "set beats clear", mis_flag, 1);
        chk("R9", "no trap when disabled", trap_req, 0);
        pulse(1, 0);
        chk("R7", "clear alone", mis_flag, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule